// File: doc/BRIEF.md
# Supply and Watchdog Reset Supervisor

This block drives a processor reset from two sources, and all of its logic runs on one clock. The first source is a digital supply-good flag from an external comparator. While that flag is low the reset is held asserted. After the flag returns high, the reset stays asserted for a fixed pulse width. The second source is a watchdog that watches a service pin. If the pin stays at one level for the full timeout, the watchdog starts a reset pulse of the same fixed width. The watchdog does not count while reset is asserted or while the service pin is reported as undriven.

All durations are counted in ticks. A prescaler divides the clock by `TICK_DIV` to make each tick, so a fast simulation and a real timing (a 200 ms pulse and a 1.6 s timeout) differ only in their parameters. A raw supply-good flag that goes low clears the block asynchronously, so the reset output falls without waiting for a clock edge. The supply flag, the service pin level and the undriven flag each pass through two flip-flops before they are used. A second comparator flag is passed through as an active-low power-fail output and has no effect on reset.

Top module: `rst_supervisor`

## Requirements
- R1: Whenever `supply_ok_i` is low, `rst_n_o` is low, with no wait for a clock edge.
- R2: After `supply_ok_i` rises, `rst_n_o` goes high exactly 2 + PULSE_TICKS*TICK_DIV clock edges later.
- R3: If `supply_ok_i` drops during a reset pulse, the pulse starts again. The release comes 2 + PULSE_TICKS*TICK_DIV edges after the supply returns, whatever the point at which the dip happened.
- R4: A watchdog timeout asserts reset for exactly PULSE_TICKS*TICK_DIV clock cycles.
- R5: The watchdog stays cleared while reset is asserted. After any release with the service pin steady and driven, the next timeout comes exactly WD_TICKS*TICK_DIV cycles later.
- R6: While `wdog_open_i` is high, the watchdog stays cleared and no timeout occurs. After it falls, with the pin steady, the timeout comes 2 + WD_TICKS*TICK_DIV edges later.
- R7: A rising or a falling change of `wdog_level_i` services the watchdog. The timeout then comes 3 + WD_TICKS*TICK_DIV edges after the change. Changes spaced closer than the timeout keep reset released.
- R8: If the service pin is held at a constant level, reset pulses repeat with a period of (WD_TICKS + PULSE_TICKS)*TICK_DIV cycles.
- R9: `rst_o` is always the inverse of `rst_n_o`.
- R10: `pfail_n_o` equals the inverse of `pf_below_i` at all times, including while reset is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| supply_ok_i | input | 1 | Supply-above-threshold flag; a low level clears the block asynchronously |
| wdog_level_i | input | 1 | Watchdog service pin level |
| wdog_open_i | input | 1 | High when the service pin is undriven |
| pf_below_i | input | 1 | High when the power-fail comparator input is below its reference |
| rst_n_o | output | 1 | Active-low processor reset |
| rst_o | output | 1 | Active-high processor reset |
| pfail_n_o | output | 1 | Active-low power-fail indication |

## Verification
The hardest case to reach is a supply dip that lands part-way through a reset pulse. Each dip position has to lead to the same full restart. The stimulus sweeps the dip over every clock position inside the pulse. After each dip it measures the cycles to release and compares them with the figure computed from the parameters. The watchdog timings also need a set starting point. Each of those measurements starts from an event the bench controls: a release, the undriven flag falling, or a single pin change.

// File: rtl/rst_supervisor.sv
module rst_supervisor #(
  parameter int TICK_DIV    = 50000,
  parameter int PULSE_TICKS = 200,
  parameter int WD_TICKS    = 1600
) (
  input  logic clk_i,
  input  logic supply_ok_i,
  input  logic wdog_level_i,
  input  logic wdog_open_i,
  input  logic pf_below_i,
  output logic rst_n_o,
  output logic rst_o,
  output logic pfail_n_o
);
  localparam int PW = $clog2(TICK_DIV + 1);
  localparam int CW = $clog2(PULSE_TICKS + 1);
  localparam int WW = $clog2(WD_TICKS + 1);

  logic [1:0]    sup_s;
  logic [2:0]    wd_s;
  logic [1:0]    open_s;
  logic          in_rst;
  logic [PW-1:0] pre;
  logic [CW-1:0] pcnt;
  logic [WW-1:0] wcnt;

  wire tick   = (pre == PW'(TICK_DIV - 1));
  wire wd_clr = open_s[1] | (wd_s[1] ^ wd_s[2]);

  always_ff @(posedge clk_i or negedge supply_ok_i) begin
    if (!supply_ok_i) begin
      sup_s  <= '0;
      wd_s   <= '0;
      open_s <= '1;
      in_rst <= 1'b1;
      pre    <= '0;
      pcnt   <= '0;
      wcnt   <= '0;
    end else begin
      sup_s  <= {sup_s[0], 1'b1};
      wd_s   <= {wd_s[1:0], wdog_level_i};
      open_s <= {open_s[0], wdog_open_i};
      if (!sup_s[1]) begin
        in_rst <= 1'b1;
        pre    <= '0;
        pcnt   <= '0;
        wcnt   <= '0;
      end else if (in_rst) begin
        wcnt <= '0;
        pre  <= tick ? '0 : pre + 1'b1;
        if (tick) begin
          if (pcnt == CW'(PULSE_TICKS - 1)) begin
            in_rst <= 1'b0;
            pcnt   <= '0;
          end else begin
            pcnt <= pcnt + 1'b1;
          end
        end
      end else if (wd_clr) begin
        wcnt <= '0;
        pre  <= '0;
      end else begin
        pre <= tick ? '0 : pre + 1'b1;
        if (tick) begin
          if (wcnt == WW'(WD_TICKS - 1)) begin
            in_rst <= 1'b1;
            wcnt   <= '0;
          end else begin
            wcnt <= wcnt + 1'b1;
          end
        end
      end
    end
  end

  assign rst_n_o   = ~in_rst & sup_s[1];
  assign rst_o     = ~rst_n_o;
  assign pfail_n_o = ~pf_below_i;
endmodule

// File: rtl/rst_supervisor_chk.sv
module rst_supervisor_chk #(
  parameter int PULSE_TICKS = 200,
  parameter int WD_TICKS    = 1600,
  parameter int CW          = 8,
  parameter int WW          = 11
) (
  input logic          clk_i,
  input logic          supply_ok_i,
  input logic          rst_n_o,
  input logic          rst_o,
  input logic          in_rst,
  input logic [CW-1:0] pcnt,
  input logic [WW-1:0] wcnt,
  input logic          open_hold,
  input logic [2:0]    wd_s
);
  a_r1_supply_low_holds: assert property (@(posedge clk_i)
    !supply_ok_i |-> !rst_n_o);

  a_r2_release_after_full_pulse: assert property (@(posedge clk_i) disable iff (!supply_ok_i)
    $rose(rst_n_o) |-> $past(pcnt) == CW'(PULSE_TICKS - 1));

  a_r4_fall_from_timeout: assert property (@(posedge clk_i) disable iff (!supply_ok_i)
    $fell(rst_n_o) |-> $past(wcnt) == WW'(WD_TICKS - 1));

  a_r5_frozen_in_reset: assert property (@(posedge clk_i) disable iff (!supply_ok_i)
    in_rst |=> wcnt == '0);

  a_r6_open_holds_clear: assert property (@(posedge clk_i) disable iff (!supply_ok_i)
    open_hold |=> wcnt == '0);

  a_r7_change_services: assert property (@(posedge clk_i) disable iff (!supply_ok_i)
    (wd_s[1] != wd_s[2]) && !in_rst |=> wcnt == '0);

  a_r9_outputs_complement: assert property (@(posedge clk_i)
    rst_o != rst_n_o);
endmodule

bind rst_supervisor rst_supervisor_chk #(
  .PULSE_TICKS(PULSE_TICKS), .WD_TICKS(WD_TICKS), .CW(CW), .WW(WW)
) u_chk (
  .clk_i(clk_i), .supply_ok_i(supply_ok_i), .rst_n_o(rst_n_o), .rst_o(rst_o),
  .in_rst(in_rst), .pcnt(pcnt), .wcnt(wcnt), .open_hold(open_s[1]), .wd_s(wd_s)
);

// File: tb/rst_supervisor_test.sv
module rst_supervisor_test;
  localparam int D = 4;
  localparam int P = 5;
  localparam int W = 8;

  logic clk = 1'b0;
  logic supply_ok = 1'b0, wdi = 1'b0, wopen = 1'b1, pf = 1'b0;
  logic rst_n, rst, pfail_n;
  int checks = 0, fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  rst_supervisor #(.TICK_DIV(D), .PULSE_TICKS(P), .WD_TICKS(W)) uut (
    .clk_i(clk), .supply_ok_i(supply_ok), .wdog_level_i(wdi), .wdog_open_i(wopen),
    .pf_below_i(pf), .rst_n_o(rst_n), .rst_o(rst), .pfail_n_o(pfail_n));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic count_until(input logic want, output int n);
    n = 0;
    do begin
      @(posedge clk); n++;
      @(negedge clk);
    end while (rst_n != want && n < 5000);
  endtask

  int n;
  int lows;

  initial begin
    repeat (5) @(negedge clk);
    check(rst_n == 1'b0, "R1", rst_n, 0);
    check(rst == ~rst_n, "R9", rst, ~rst_n);
    pf = 1'b1; #1;
    check(pfail_n == 1'b0, "R10", pfail_n, 0);
    @(negedge clk);
    supply_ok = 1'b1;
    count_until(1'b1, n);
    check(n == 2 + P*D, "R2", n, 2 + P*D);
    check(rst == 1'b0, "R9", rst, 0);
    pf = 1'b0; #1;
    check(pfail_n == 1'b1, "R10", pfail_n, 1);

    lows = 0;
    for (int i = 0; i < 3*W*D; i++) begin
      @(negedge clk);
      if (!rst_n) lows++;
    end
    check(lows == 0, "R6", lows, 0);
    wopen = 1'b0;
    count_until(1'b0, n);
    check(n == 2 + W*D, "R6", n, 2 + W*D);
    pf = 1'b1; #1;
    check(pfail_n == 1'b0, "R10", pfail_n, 0);
    pf = 1'b0;

    count_until(1'b1, n);
    check(n == P*D, "R4", n, P*D);
    count_until(1'b0, n);
    check(n == W*D, "R5", n, W*D);
    lows = n;
    count_until(1'b1, n);
    check(n == P*D, "R4", n, P*D);
    check(lows + n == (W + P)*D, "R8", lows + n, (W + P)*D);
    for (int rep = 0; rep < 3; rep++) begin
      count_until(1'b0, n);
      lows = n;
      count_until(1'b1, n);
      check(lows + n == (W + P)*D, "R8", lows + n, (W + P)*D);
    end

    lows = 0;
    for (int i = 0; i < 20; i++) begin
      repeat (10) @(negedge clk);
      if (!rst_n) lows++;
      wdi = ~wdi;
    end
    check(lows == 0, "R7", lows, 0);
    @(negedge clk);
    count_until(1'b1, n);
    @(negedge clk);
    wdi = 1'b1;
    repeat (W*D/2) @(negedge clk);
    wdi = 1'b0;
    count_until(1'b0, n);
    check(n == 3 + W*D, "R7", n, 3 + W*D);
    count_until(1'b1, n);
    repeat (W*D/2) @(negedge clk);
    wdi = 1'b1;
    count_until(1'b0, n);
    check(n == 3 + W*D, "R7", n, 3 + W*D);

    for (int k = 1; k < P*D; k++) begin
      @(negedge clk);
      supply_ok = 1'b0; #1;
      check(rst_n == 1'b0, "R1", rst_n, 0);
      @(negedge clk);
      supply_ok = 1'b1;
      repeat (k) @(negedge clk);
      check(rst_n == 1'b0, "R3", rst_n, 0);
      supply_ok = 1'b0;
      repeat (2) @(negedge clk);
      supply_ok = 1'b1;
      count_until(1'b1, n);
      check(n == 2 + P*D, "R3", n, 2 + P*D);
    end

    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule